// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns five asynchronous interrupt pins and a group of five key inputs into sticky interrupt request flags, one per channel. Each channel has an 8-bit control register. The register sets level or edge sensing, the active polarity and a 3-bit priority level, and it holds the request flag itself. A single polarity bit sets both the active level and the edge direction. Before any detection, every pin and key passes through a synchronizer chain.

Channel 3 can take its source from its own pin, from the lower four keys or from all five keys. A selected key group acts as one source: it is active when any key in the group is active. Channel 4 comes out of reset write-protected. Its register only accepts writes after software sets the unlock register. The request flags and the priority fields leave the block on plain wires. An acknowledge pulse from the interrupt controller names one channel and clears its flag. Software can also clear a flag, but it can never set one.

Top module: `ext_irq_cond`

## Requirements
- R1: Control register bit 5 selects the sensing mode: 0 means edge sensing and 1 means level sensing. Bit 4 is the polarity bit. Bits 2:0 hold the priority level, and bit 3 is the request flag.
- R2: With polarity 0, a channel in level mode sets its request on every cycle its input is high. In edge mode it sets the request only on a high-to-low transition. A low-to-high transition sets nothing.
- R3: With polarity 1, a channel in level mode sets its request on every cycle its input is low. In edge mode it sets the request only on a low-to-high transition.
- R4: A request flag stays set after its cause goes away. It is cleared only by an acknowledge, by a software clear or by reset.
- R5: When `ack_valid` is high, the channel numbered by `ack_chan` has its request cleared at the next edge. A set event in the same cycle wins over the acknowledge.
- R6: A register write with bit 3 equal to 0 clears the request. A write with bit 3 equal to 1 leaves the request unchanged. No write ever sets a request.
- R7: On channel 3, register bits 7:6 choose the source. 00 selects pin 3. 10 selects keys 3..0, and 11 selects keys 4..0. A key group is active when any of its keys is at the active level set by the polarity bit. Bits 7:6 read back on channel 3 and read as 0 on every other channel.
- R8: On channel 3, source code 01 produces no requests, whatever the pins, the keys or the mode.
- R9: After reset, writes to channel 4 have no effect until bit 0 of the unlock register (address 5) is 1. While channel 4 is locked, a write does not clear its request either.
- R10: An input change applied before clock edge n shows on `req_out` after edge n+2 and not before.
- R11: Reset clears every register to 0: configurations, request flags, the channel 3 source code and the unlock bit.
- R12: `rd_data` shows channel register i at address i (0 to 4) and the unlock register at address 5. Addresses 6 and 7 read as 0. `req_lvl[3i+2:3i]` carries channel i's priority field.
- R13: Writing a channel's configuration does not, by itself, cause an edge-mode request. Edge detection is suppressed for the cycle after each accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0-4 channels, 5 unlock) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| pin_in | input | 5 | Asynchronous interrupt pins |
| key_in | input | 5 | Asynchronous key inputs |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_chan | input | 3 | Channel being acknowledged |
| req_out | output | 5 | Request flag per channel |
| req_lvl | output | 15 | Priority level per channel, 3 bits each |

## Verification
The assertions take for granted that a request flag rises only from a detected set event. Outside reset, flags are lowered only by an acknowledge or an accepted software clear. They also assume that the channel 3 source code and the channel 4 lock can change only through accepted writes. The stimulus holds pins and keys stable for several cycles around every configuration write. It clears flags after each reconfiguration, before applying the transition under test. Expected values therefore depend only on the old and new input values, not on where the synchronizer stages sit. Acknowledges and writes always address existing channels.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  localparam int REG_W    = 8;
  localparam int LVL_W    = 3;
  localparam int CFG_W    = 6;
  localparam int REQ_BIT  = 3;
  localparam int POL_BIT  = 4;
  localparam int MODE_BIT = 5;
  localparam int SEL_LSB  = 6;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_RSV  = 2'b01,
    SRC_NARR = 2'b10,
    SRC_WIDE = 2'b11
  } src_sel_e;

  // bit order matches register bits 5:0
  typedef struct packed {
    logic             mode;
    logic             pol;
    logic             req;
    logic [LVL_W-1:0] lvl;
  } chan_cfg_t;
endpackage

// File: rtl/ext_irq_sync.sv
`timescale 1ns/1ps
module ext_irq_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_in;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_keymux.sv
`timescale 1ns/1ps
module ext_irq_keymux
  import ext_irq_pkg::*;
#(
  parameter int KEY_W      = 5,
  parameter int KEY_NARROW = 4
) (
  input  logic             pin_s,
  input  logic [KEY_W-1:0] keys_s,
  input  logic             pol,
  input  logic [1:0]       sel,
  output logic             hit,
  output logic             ok
);
  logic [KEY_W-1:0] key_act;
  logic             any_narrow;
  logic             any_wide;

  assign key_act    = keys_s ^ {KEY_W{pol}};
  assign any_narrow = |key_act[KEY_NARROW-1:0];
  assign any_wide   = |key_act;

  always_comb begin
    hit = 1'b0;
    ok  = 1'b1;
    unique case (src_sel_e'(sel))
      SRC_PIN:  hit = pin_s ^ pol;
      SRC_NARR: hit = any_narrow;
      SRC_WIDE: hit = any_wide;
      default:  ok  = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_irq_chan.sv
`timescale 1ns/1ps
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CFG_W-1:0] wr_cfg,
  input  logic             ack_hit,
  input  logic             hit_in,
  input  logic             ok_in,
  output logic [LVL_W-1:0] lvl_o,
  output logic             pol_o,
  output logic             mode_o,
  output logic             req_o,
  output logic             set_evt_o
);
  chan_cfg_t cfg_q;
  logic      prev_q;
  logic      mask_q;
  logic      sw_clr;

  // hit_in is already polarity-adjusted: an edge event is hit_in leaving 1
  assign set_evt_o = ok_in & (cfg_q.mode ? hit_in : (prev_q & ~hit_in & ~mask_q));
  assign sw_clr    = wr_hit & ~wr_cfg[REQ_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      prev_q <= hit_in;
      mask_q <= wr_hit;
      if (wr_hit) begin
        cfg_q.mode <= wr_cfg[MODE_BIT];
        cfg_q.pol  <= wr_cfg[POL_BIT];
        cfg_q.lvl  <= wr_cfg[LVL_W-1:0];
      end
      cfg_q.req <= set_evt_o | (cfg_q.req & ~ack_hit & ~sw_clr);
    end
  end

  assign lvl_o  = cfg_q.lvl;
  assign pol_o  = cfg_q.pol;
  assign mode_o = cfg_q.mode;
  assign req_o  = cfg_q.req;
endmodule

// File: rtl/ext_irq_cond.sv
`timescale 1ns/1ps
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int N_CH        = 5,
  parameter int KEY_W       = 5,
  parameter int KEY_NARROW  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int KEY_CH      = 3,
  parameter int LOCK_CH     = 4,
  localparam int ADDR_W     = $clog2(N_CH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  input  logic [N_CH-1:0]         pin_in,
  input  logic [KEY_W-1:0]        key_in,
  input  logic                    ack_valid,
  input  logic [ADDR_W-1:0]       ack_chan,
  output logic [N_CH-1:0]         req_out,
  output logic [N_CH*LVL_W-1:0]   req_lvl
);
  localparam logic [ADDR_W-1:0] UNLOCK_ADDR = ADDR_W'(N_CH);

  logic [N_CH-1:0]  pin_s;
  logic [KEY_W-1:0] key_s;
  logic [N_CH-1:0]  pol;
  logic [N_CH-1:0]  mode;
  logic [N_CH-1:0]  set_evt;
  logic [N_CH-1:0]  wr_hit;
  logic [LVL_W-1:0] lvl [N_CH];
  logic [REG_W-1:0] reg_view [N_CH];
  logic [1:0]       key_sel_q;
  logic             unlock_q;
  logic             kmux_hit;
  logic             kmux_ok;

  ext_irq_sync #(.W(N_CH + KEY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({key_in, pin_in}),
    .d_out ({key_s, pin_s})
  );

  ext_irq_keymux #(.KEY_W(KEY_W), .KEY_NARROW(KEY_NARROW)) u_kmux (
    .pin_s  (pin_s[KEY_CH]),
    .keys_s (key_s),
    .pol    (pol[KEY_CH]),
    .sel    (key_sel_q),
    .hit    (kmux_hit),
    .ok     (kmux_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlock_q  <= 1'b0;
      key_sel_q <= 2'b00;
    end else begin
      if (wr_en && wr_addr == UNLOCK_ADDR) unlock_q <= wr_data[0];
      if (wr_hit[KEY_CH]) key_sel_q <= wr_data[SEL_LSB +: 2];
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic hit_i;
    logic ok_i;

    if (i == LOCK_CH) begin : g_lock
      assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i)) && unlock_q;
    end else begin : g_open
      assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    if (i == KEY_CH) begin : g_keysrc
      assign hit_i = kmux_hit;
      assign ok_i  = kmux_ok;
      assign reg_view[i] = {key_sel_q, mode[i], pol[i], req_out[i], lvl[i]};
    end else begin : g_pinsrc
      assign hit_i = pin_s[i] ^ pol[i];
      assign ok_i  = 1'b1;
      assign reg_view[i] = {2'b00, mode[i], pol[i], req_out[i], lvl[i]};
    end

    ext_irq_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit[i]),
      .wr_cfg    (wr_data[CFG_W-1:0]),
      .ack_hit   (ack_valid && (ack_chan == ADDR_W'(i))),
      .hit_in    (hit_i),
      .ok_in     (ok_i),
      .lvl_o     (lvl[i]),
      .pol_o     (pol[i]),
      .mode_o    (mode[i]),
      .req_o     (req_out[i]),
      .set_evt_o (set_evt[i])
    );

    assign req_lvl[i*LVL_W +: LVL_W] = lvl[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = reg_view[i];
    end
    if (rd_addr == UNLOCK_ADDR) rd_data = {{(REG_W-1){1'b0}}, unlock_q};
  end
endmodule

// File: rtl/ext_irq_cond_chk.sv
`timescale 1ns/1ps
module ext_irq_cond_chk #(
  parameter int N_CH    = 5,
  parameter int KEY_CH  = 3,
  parameter int LOCK_CH = 4,
  parameter int ADDR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              ack_valid,
  input logic [ADDR_W-1:0] ack_chan,
  input logic [N_CH-1:0]   req_out,
  input logic [N_CH-1:0]   set_evt,
  input logic [1:0]        key_sel,
  input logic              lock_open,
  input logic [7:0]        lock_reg
);
  for (genvar i = 0; i < N_CH; i++) begin : g_a
    // R5: a set event wins and the flag is up next cycle
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> req_out[i]);
    // R5: acknowledge clears when no set event competes
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_chan == ADDR_W'(i) && !set_evt[i]) |=> !req_out[i]);
    // R6: accepted software clear lowers the flag
    assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(i) && !wr_data[3] && !set_evt[i]
       && (i != LOCK_CH || lock_open)) |=> !req_out[i]);
    // R4 and R6: a flag never rises without a set event
    assert_no_spont_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_out[i] && !set_evt[i]) |=> !req_out[i]);
  end

  // R8: reserved source code stays silent
  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_sel == 2'b01) |-> !set_evt[KEY_CH]);

  // R9: locked channel keeps its configuration
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(LOCK_CH) && !lock_open)
      |=> ($stable(lock_reg[2:0]) && $stable(lock_reg[5:4])));
endmodule

bind ext_irq_cond ext_irq_cond_chk #(
  .N_CH(N_CH), .KEY_CH(KEY_CH), .LOCK_CH(LOCK_CH), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ack_valid (ack_valid),
  .ack_chan  (ack_chan),
  .req_out   (req_out),
  .set_evt   (set_evt),
  .key_sel   (key_sel_q),
  .lock_open (unlock_q),
  .lock_reg  (reg_view[LOCK_CH])
);

// File: tb/ext_irq_cond_bench.sv
`timescale 1ns/1ps
module ext_irq_cond_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] pin_in = '0;
  logic [4:0] key_in = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_chan = '0;
  logic [4:0] req_out;
  logic [14:0] req_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_cond u_ext_irq_cond (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .key_in(key_in),
    .ack_valid(ack_valid), .ack_chan(ack_chan), .req_out(req_out), .req_lvl(req_lvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic ack(input logic [2:0] c);
    @(negedge clk);
    ack_valid = 1'b1; ack_chan = c;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  function automatic logic act_f(int ch, logic [4:0] p, logic [4:0] k, logic pol, logic [1:0] sel);
    if (ch != 3) return p[ch] ^ pol;
    case (sel)
      2'b00:   return p[3] ^ pol;
      2'b10:   return |(k[3:0] ^ {4{pol}});
      2'b11:   return |(k ^ {5{pol}});
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ok_f(int ch, logic [1:0] sel);
    return (ch != 3) || (sel != 2'b01);
  endfunction

  initial begin
    cyc(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);

    // R11 reset state
    chk("R11 req_out after reset", req_out, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R11 register after reset", d, 0);
    end
    // R12 unused addresses
    rd(3'd7, d);
    chk("R12 unused address reads 0", d, 0);

    // R9 locked channel 4
    wr(3'd4, 8'h25);
    rd(3'd4, d);
    chk("R9 locked write ignored", d, 0);
    wr(3'd5, 8'h01);
    rd(3'd5, d);
    chk("R12 unlock readback", d, 1);
    wr(3'd4, 8'h2D);
    rd(3'd4, d);
    chk("R9 R6 unlocked write, req bit 1 does not set", d, 8'h25);
    chk("R12 req_lvl of channel 4", req_lvl[14:12], 3'd5);
    wr(3'd4, 8'h00);

    // R10 latency and R2 edge direction on channel 1 (reset config: edge, polarity 0)
    @(negedge clk); pin_in[1] = 1'b1;
    cyc(5);
    chk("R2 rising edge ignored at polarity 0", req_out[1], 0);
    @(negedge clk); pin_in[1] = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 not yet visible after two edges", req_out[1], 0);
    @(posedge clk); #1;
    chk("R10 visible after third edge", req_out[1], 1);
    cyc(4);
    chk("R4 edge request sticky", req_out[1], 1);
    ack(3'd1);
    chk("R5 acknowledge clears", req_out[1], 0);

    // R6 software clear on channel 2
    @(negedge clk); pin_in[2] = 1'b1;
    cyc(4);
    @(negedge clk); pin_in[2] = 1'b0;
    cyc(5);
    chk("R2 falling edge sets channel 2", req_out[2], 1);
    wr(3'd2, 8'h08);
    chk("R6 write with req 1 keeps flag", req_out[2], 1);
    wr(3'd2, 8'h00);
    chk("R6 write with req 0 clears flag", req_out[2], 0);

    // R13 reconfiguration alone causes no edge
    @(negedge clk); pin_in[0] = 1'b1;
    cyc(5);
    wr(3'd0, 8'h10);
    cyc(5);
    chk("R13 polarity change makes no event", req_out[0], 0);
    wr(3'd0, 8'h00);
    cyc(3);

    // R5 level active: acknowledge loses to set
    wr(3'd0, 8'h20);
    cyc(4);
    ack(3'd0);
    chk("R5 level-active set beats acknowledge", req_out[0], 1);
    @(negedge clk); pin_in[0] = 1'b0;
    cyc(5);
    chk("R4 level request sticky after release", req_out[0], 1);
    ack(3'd0);
    chk("R5 acknowledge after release", req_out[0], 0);

    // R8 reserved code with keys active
    wr(3'd3, 8'h60);
    @(negedge clk); key_in = 5'h1F; pin_in[3] = 1'b1;
    cyc(6);
    chk("R8 reserved source quiet", req_out[3], 0);
    rd(3'd3, d);
    chk("R7 source code reads back", d[7:6], 2'b01);

    // random section
    void'($urandom(32'h5eed_0042));
    for (int it = 0; it < 300; it++) begin
      int ch;
      logic [2:0] lvl;
      logic pol, lm;
      logic [1:0] sel;
      logic [4:0] p_old, p_new, k_old, k_new;
      logic e;
      logic [7:0] cfg;
      ch  = $urandom % 5;
      lvl = 3'($urandom);
      pol = 1'($urandom);
      lm  = 1'($urandom);
      sel = (ch == 3) ? 2'($urandom) : 2'b00;
      cfg = {sel, lm, pol, 1'b0, lvl};
      p_old = 5'($urandom); k_old = 5'($urandom);
      p_new = 5'($urandom); k_new = 5'($urandom);
      @(negedge clk); pin_in = p_old; key_in = k_old;
      cyc(4);
      wr(3'(ch), cfg);
      cyc(3);
      wr(3'(ch), cfg);
      cyc(2);
      @(negedge clk); pin_in = p_new; key_in = k_new;
      cyc(6);
      if (lm)
        e = ok_f(ch, sel) & (act_f(ch, p_old, k_old, pol, sel) | act_f(ch, p_new, k_new, pol, sel));
      else
        e = ok_f(ch, sel) & act_f(ch, p_old, k_old, pol, sel) & ~act_f(ch, p_new, k_new, pol, sel);
      if (ch == 3 && sel == 2'b01) chk("R8 random reserved", req_out[ch], e);
      else if (ch == 3 && sel[1]) chk("R7 random key group", req_out[ch], e);
      else if (lm) chk(pol ? "R3 random level" : "R2 random level", req_out[ch], e);
      else chk(pol ? "R3 random edge" : "R2 random edge", req_out[ch], e);
      rd(3'(ch), d);
      chk("R1 R12 random readback", d, {sel, lm, pol, e, lvl});
      chk("R12 random req_lvl", req_lvl[ch*3 +: 3], lvl);
      ack(3'(ch));
      chk("R5 random acknowledge",
          req_out[ch], ok_f(ch, sel) & lm & act_f(ch, p_new, k_new, pol, sel));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule